// File: doc/BRIEF.md
# Vector display-list program counter with return stack

This block holds the 14-bit address a vector graphics generator uses to walk its display list. The address is always driven on `addr_out`. A falling edge on the active-low strobe, qualified by an enable line, applies one of four operations chosen by a 2-bit code. The operations are clear, jump, call and return. A fifth operation, increment, runs on its own on every clock while the increment-inhibit input is low and the strobe line is idle.

Calls and returns go through a three-slot return stack addressed by a 2-bit pointer. The pointer steps 0, 1, 2, 0 on calls and runs the other way on returns. The pointer comes out of reset in the unused fourth state (3), as the block can after power-up. A call from that state stores nothing and moves the pointer to 0.

A jump does not land all at once. The upper thirteen bits are taken on the clock that sees the strobe fall. Bit 0 is only taken from the data bus at the next rising edge of the separate timing clock `tclk`, and only if the strobe is still held low at that edge. Stack slots are never cleared. A return from an empty stack is not trapped: it reads whatever the wrapped slot holds.

Top module: `vec_pc_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_out` becomes 0 and the stack pointer is set to its power-up state 3.
- R2: A strobed operation with `op_code` 2'b00 clears `addr_out` to 0 and sets the stack pointer to 0, one clock after the strobe fall.
- R3: On every clock with `inc_inhibit` low and `strobe_n` high, `addr_out` increases by one modulo 2^14. With `inc_inhibit` high, or with `strobe_n` low, it holds.
- R4: A strobed jump (`op_code` 2'b01) loads `addr_out[13:1]` from `target[13:1]` one clock after the strobe fall and leaves `addr_out[0]` unchanged.
- R5: After a jump, `addr_out[0]` takes `target[0]` one clock after the first rising edge of `tclk` seen while `strobe_n` stays low. If the strobe is released first, bit 0 is never taken.
- R6: A strobed call (`op_code` 2'b10) writes the current `addr_out` into the slot at the pointer, advances the pointer, and loads all 14 bits of `target`.
- R7: A strobed return (`op_code` 2'b11) steps the pointer back and loads `addr_out` from the slot at the new pointer.
- R8: The pointer moves 0→1→2→0 on calls and 0→2→1→0 on returns. From state 3, a call goes to 0 without storing and a return goes to 2. A return from an empty stack is not trapped.
- R9: A strobe fall with `op_en` low changes neither `addr_out` nor the stack.
- R10: A strobe held low for several clocks applies its operation once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| op_en | input | 1 | Enables the strobed operation |
| op_code | input | 2 | 00 clear, 01 jump, 10 call, 11 return |
| strobe_n | input | 1 | Active-low operation strobe, acted on at its falling edge |
| tclk | input | 1 | Timing clock; its rising edge commits jump bit 0 |
| inc_inhibit | input | 1 | High blocks the per-clock increment |
| target | input | 14 | Jump and call target address |
| addr_out | output | 14 | Current program counter |

## Verification
Every strobed result is due on the first clock edge that sees the strobe low. Jump bit 0 is due on the first clock edge that sees `tclk` high while the strobe is still held, and an increment lands on every clock edge with the inhibit low. The bench changes inputs only on falling clock edges. It reads `addr_out` on a later falling edge, once every edge it has counted has passed. For jumps it checks the intermediate value before the `tclk` pulse as well as the final one. For held strobes and blocked increments it counts the exact number of edges, so that a result landing one clock early, one clock late, or more than once shows up.

// File: rtl/vpc_pkg.sv
// Shared definitions for the vector program counter.
// Assumes a 2-bit operation code driven by the surrounding sequencer.
package vpc_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR  = 2'b00,
        OP_JUMP   = 2'b01,
        OP_CALL   = 2'b10,
        OP_RETURN = 2'b11
    } vpc_op_e;
endpackage

// File: rtl/vpc_edge_det.sv
// Single-edge detector for a slow control line sampled by clk.
// RISING=1 flags 0->1 transitions, RISING=0 flags 1->0 transitions.
// Assumes the line is already synchronous to clk; the flag lasts one clock.
module vpc_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    localparam logic IDLE = RISING ? 1'b0 : 1'b1;

    logic sig_q;

    // Remember last sampled level; reset to the idle level so reset adds no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= IDLE;
        else        sig_q <= sig_i;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sig_i & ~sig_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & sig_q;
        end
    endgenerate
endmodule

// File: rtl/vpc_ret_stack.sv
// Return-address stack: DEPTH slots of AW bits and a PTR_W-bit pointer.
// The pointer wraps modulo DEPTH. Codes at or above DEPTH are illegal states,
// reachable only through reset with PWRUP_PTR. A push from an illegal state
// stores nothing and moves to 0; a pop from one moves to DEPTH-1.
// Slots have no reset. rd_data shows the slot a pop would read.
module vpc_ret_stack #(
    parameter int AW        = 14,
    parameter int DEPTH     = 3,
    parameter int PTR_W     = 2,
    parameter int PWRUP_PTR = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] rd_data
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] INIT = PTR_W'(PWRUP_PTR);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;
    logic [AW-1:0]    slot_q [DEPTH];

    // Next pointer for a push: wrap from the last legal slot or any illegal code.
    always_comb begin
        if (ptr_q >= LAST) ptr_up = '0;
        else               ptr_up = ptr_q + 1'b1;
    end

    // Next pointer for a pop: wrap from 0, and leave illegal codes for the top slot.
    always_comb begin
        if (ptr_q == '0 || ptr_q > LAST) ptr_dn = LAST;
        else                             ptr_dn = ptr_q - 1'b1;
    end

    // Pointer register: power-up code on reset, then clear/push/pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= INIT;
        else if (clear) ptr_q <= '0;
        else if (push)  ptr_q <= ptr_up;
        else if (pop)   ptr_q <= ptr_dn;
    end

    // One storage row per slot, written only on a push that points at it.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && !clear && ptr_q == PTR_W'(i)) slot_q[i] <= wr_data;
            end
        end
    endgenerate

    // Read port feeds the program counter during a pop.
    always_comb begin
        rd_data = slot_q[ptr_dn];
    end

    // R8: a push from the last legal slot or an illegal code lands on 0.
    a_r8_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && ptr_q >= LAST) |=> (ptr_q == '0));

    // R8: once legal, the pointer never returns to an illegal code.
    a_r8_stay_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q <= LAST) |=> (ptr_q <= LAST));

    // R9: with no stack operation the pointer holds.
    a_r9_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !clear) |=> $stable(ptr_q));
endmodule

// File: rtl/vpc_addr_reg.sv
// Program-counter register with fixed priority.
// Order: clear, jump, call, return, bit-0 commit, increment.
// A jump loads bits AW-1:1 only; bit 0 waits for the commit strobe.
// Assumes at most one of clear/jump/call/ret is high in a cycle.
module vpc_addr_reg #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          jump,
    input  logic          call,
    input  logic          ret,
    input  logic          commit,
    input  logic          inc,
    input  logic [AW-1:0] target,
    input  logic          bit0_val,
    input  logic [AW-1:0] pop_data,
    output logic [AW-1:0] pc
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;

    // Select the next counter value by priority.
    always_comb begin
        pc_d = pc_q;
        if (clear)       pc_d = '0;
        else if (jump)   pc_d = {target[AW-1:1], pc_q[0]};
        else if (call)   pc_d = target;
        else if (ret)    pc_d = pop_data;
        else if (commit) pc_d = {pc_q[AW-1:1], bit0_val};
        else if (inc)    pc_d = pc_q + 1'b1;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    // R2: a clear leaves the counter at zero.
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pc_q == '0));

    // R4: a jump keeps the previous bit 0 and takes the upper target bits.
    a_r4_jump_split: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && !clear) |=> (pc_q[0] == $past(pc_q[0]) &&
                              pc_q[AW-1:1] == $past(target[AW-1:1])));

    // R3: with no request of any kind the counter holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !jump && !call && !ret && !commit && !inc) |=> $stable(pc_q));
endmodule

// File: rtl/vec_pc_stack.sv
// Top level: display-list program counter with a three-level return stack.
// Strobe and timing clock are sampled by clk and edge-detected. Bit 0 of a
// jump waits for a tclk rise while the strobe is held. Increment runs each
// clock while inc_inhibit is low and no strobe is held.
// Assumes all inputs are synchronous to clk.
module vec_pc_stack #(
    parameter int ADDR_W    = 14,
    parameter int DEPTH     = 3,
    parameter int PWRUP_PTR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [1:0]        op_code,
    input  logic              strobe_n,
    input  logic              tclk,
    input  logic              inc_inhibit,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] addr_out
);
    import vpc_pkg::*;

    localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH + 1);

    vpc_op_e          op;
    logic             strb_fall;
    logic             tclk_rise;
    logic             evt;
    logic             do_clear;
    logic             do_jump;
    logic             do_call;
    logic             do_ret;
    logic             do_commit;
    logic             do_inc;
    logic             bit0_pend_q;
    logic [ADDR_W-1:0] pop_data;

    vpc_edge_det #(.RISING(1'b0)) u_strb_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(strobe_n), .edge_o(strb_fall)
    );

    vpc_edge_det #(.RISING(1'b1)) u_tclk_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(tclk), .edge_o(tclk_rise)
    );

    // Decode one operation per qualified strobe fall.
    always_comb begin
        op        = vpc_op_e'(op_code);
        evt       = strb_fall & op_en;
        do_clear  = evt && (op == OP_CLEAR);
        do_jump   = evt && (op == OP_JUMP);
        do_call   = evt && (op == OP_CALL);
        do_ret    = evt && (op == OP_RETURN);
        do_commit = bit0_pend_q & tclk_rise & ~strobe_n;
        do_inc    = ~inc_inhibit & strobe_n;
    end

    // Track a jump whose bit 0 is still waiting for the timing clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                     bit0_pend_q <= 1'b0;
        else if (do_jump)               bit0_pend_q <= 1'b1;
        else if (strobe_n || do_commit) bit0_pend_q <= 1'b0;
    end

    vpc_ret_stack #(
        .AW(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .PWRUP_PTR(PWRUP_PTR)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .clear(do_clear), .push(do_call),
        .pop(do_ret), .wr_data(addr_out), .rd_data(pop_data)
    );

    vpc_addr_reg #(.AW(ADDR_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .clear(do_clear), .jump(do_jump),
        .call(do_call), .ret(do_ret), .commit(do_commit), .inc(do_inc),
        .target(target), .bit0_val(target[0]), .pop_data(pop_data),
        .pc(addr_out)
    );

    // R9: a disabled strobe fall with increment blocked leaves the address alone.
    a_r9_disabled_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_fall && !op_en && inc_inhibit) |=> $stable(addr_out));

    // R10: a strobe that stays low, with no tclk rise, never changes the address again.
    a_r10_single_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !strb_fall && !tclk_rise) |=> $stable(addr_out));

    // R5: a released strobe cancels any pending bit-0 commit.
    a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && !strb_fall) |=> !bit0_pend_q);
endmodule

// File: tb/vec_pc_stack_test.sv
`timescale 1ns/1ps
module vec_pc_stack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic        strobe_n = 1'b1;
    logic        tclk = 1'b0;
    logic        inc_inhibit = 1'b1;
    logic [13:0] target = '0;
    logic [13:0] addr_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_pc_stack uut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
        .strobe_n(strobe_n), .tclk(tclk), .inc_inhibit(inc_inhibit),
        .target(target), .addr_out(addr_out)
    );

    // Vector: {enable, code, target, expected address}; 00 clr 01 jmp 10 call 11 ret.
    localparam int NV = 16;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 2'b01, 14'h1235, 14'h1235},
        {1'b1, 2'b10, 14'h0800, 14'h0800},
        {1'b1, 2'b10, 14'h0C01, 14'h0C01},
        {1'b1, 2'b01, 14'h0C10, 14'h0C10},
        {1'b1, 2'b10, 14'h2002, 14'h2002},
        {1'b1, 2'b10, 14'h3FFF, 14'h3FFF},
        {1'b0, 2'b10, 14'h0222, 14'h3FFF},
        {1'b0, 2'b11, 14'h0000, 14'h3FFF},
        {1'b0, 2'b00, 14'h0000, 14'h3FFF},
        {1'b1, 2'b11, 14'h0000, 14'h2002},
        {1'b1, 2'b11, 14'h0000, 14'h0C10},
        {1'b1, 2'b11, 14'h0000, 14'h0800},
        {1'b1, 2'b11, 14'h0000, 14'h2002},
        {1'b1, 2'b00, 14'h1111, 14'h0000},
        {1'b1, 2'b10, 14'h0155, 14'h0155},
        {1'b1, 2'b11, 14'h0000, 14'h0000}
    };

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe an operation, pulse tclk while held, release, then settle one clock.
    task automatic strobe_op(input logic en, input logic [1:0] code, input logic [13:0] tgt);
        @(negedge clk);
        op_en = en; op_code = code; target = tgt; strobe_n = 1'b0;
        @(negedge clk);
        tclk = 1'b1;
        @(negedge clk);
        tclk = 1'b0; strobe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: addr_out=%h expected=completion", addr_out);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", addr_out, 14'h0000);
        rst_n = 1'b1;

        // Table walk: R4 R5 R6 R7 R8 R9 R10 R2 (strobe held two clocks each).
        for (int i = 0; i < NV; i++) begin
            strobe_op(VEC[i][30], VEC[i][29:28], VEC[i][27:14]);
            case (VEC[i][29:28])
                2'b00:   check(VEC[i][30] ? "R2 clear" : "R9 disabled", addr_out, VEC[i][13:0]);
                2'b01:   check("R4 jump", addr_out, VEC[i][13:0]);
                2'b10:   check(VEC[i][30] ? "R6 call R10" : "R9 disabled", addr_out, VEC[i][13:0]);
                default: check(VEC[i][30] ? "R7 R8 return" : "R9 disabled", addr_out, VEC[i][13:0]);
            endcase
        end

        // R3: four increments across the 14-bit wrap.
        strobe_op(1'b1, 2'b01, 14'h3FFD);
        check("R4 jump", addr_out, 14'h3FFD);
        inc_inhibit = 1'b0;
        repeat (4) @(negedge clk);
        inc_inhibit = 1'b1;
        check("R3 increment wrap", addr_out, 14'h0001);
        repeat (3) @(negedge clk);
        check("R3 inhibit hold", addr_out, 14'h0001);

        // R3/R9: held disabled strobe blocks increment.
        op_en = 1'b0; strobe_n = 1'b0; inc_inhibit = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 strobe blocks inc", addr_out, 14'h0001);
        strobe_n = 1'b1; inc_inhibit = 1'b1;
        @(negedge clk);

        // R4/R5: bit 0 deferred until tclk rise.
        op_en = 1'b1; op_code = 2'b01; target = 14'h0AAA; strobe_n = 1'b0;
        @(negedge clk);
        check("R4 bit0 kept", addr_out, 14'h0AAB);
        @(negedge clk);
        check("R10 held no repeat", addr_out, 14'h0AAB);
        tclk = 1'b1;
        @(negedge clk);
        check("R5 bit0 commit", addr_out, 14'h0AAA);
        tclk = 1'b0; strobe_n = 1'b1;
        @(negedge clk);

        // R5: release before tclk drops the bit-0 load.
        target = 14'h1555; strobe_n = 1'b0;
        @(negedge clk);
        check("R4 bit0 kept", addr_out, 14'h1554);
        strobe_n = 1'b1;
        @(negedge clk);
        tclk = 1'b1;
        @(negedge clk);
        tclk = 1'b0;
        @(negedge clk);
        check("R5 no late commit", addr_out, 14'h1554);

        // R1: reset mid-run, then R8 call from the power-up pointer state.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset midrun", addr_out, 14'h0000);
        rst_n = 1'b1;
        strobe_op(1'b1, 2'b10, 14'h0321);
        strobe_op(1'b1, 2'b10, 14'h0456);
        check("R6 call", addr_out, 14'h0456);
        strobe_op(1'b1, 2'b11, 14'h0000);
        check("R8 pointer from 3", addr_out, 14'h0321);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule